// File: doc/BRIEF.md
# Dual-Unit Round-Robin Issue Steering

This block takes one instruction per cycle, a valid flag plus a four-bit class code, and decides which of five execution units receives it. The units are integer ALU A, integer ALU B, floating-point ALU A, floating-point ALU B and a single memory port. Some classes may go to either unit of a pair. Others are tied to one unit, and a few of those keep their unit occupied for many cycles.

The block keeps a turn bit for each pair and an occupancy countdown for each unit. The accept and grant outputs are combinational on the current inputs and the registered state. When accept is low, the source holds the same instruction and offers it again on the next cycle. Grant bit order is 0 integer ALU A, 1 integer ALU B, 2 FP ALU A, 3 FP ALU B, 4 memory port.

Class codes: 0 integer flexible, 1 control transfer (branch, jump, call, trap), 2 integer multiply, 3 integer divide, 4 memory (load, store, prefetch), 5 simple FP (abs, neg, compare, move, convert), 6 FP flexible (add, multiply, multiply-add), 7 FP divide, 8 FP square root, 9 paired integer op, 10 to 15 unrecognised.

Top module: `issue_steer`

## Requirements
- R1: A synchronous reset clears every occupancy counter and sets both turn bits to unit A. After reset, every unit is free and the first flexible instruction of each pair goes to unit A.
- R2: A flexible integer instruction (class 0) goes to the integer unit that holds the turn. The integer turn then flips, so back-to-back flexible instructions alternate between A and B.
- R3: If the turn unit of a pair is occupied and the other unit is free, a flexible instruction (class 0 or 6) goes to the free unit. The turn still flips.
- R4: A control-transfer instruction (class 1) goes only to integer ALU A and sets the integer turn to B. An instruction tied to integer ALU B sets the turn to A. In the FP pair, an instruction tied to unit A sets the FP turn to B, and one tied to unit B sets it to A.
- R5: Integer multiply (class 2) and integer divide (class 3) go only to integer ALU B. They occupy it for 2 and 19 cycles, counting the issue cycle.
- R6: Simple FP instructions (class 5) go only to FP ALU A. FP flexible instructions (class 6) follow the FP turn in the same way R2 describes for the integer pair.
- R7: FP divide (class 7) and FP square root (class 8) go only to FP ALU B. They occupy it for 8 and 14 cycles, counting the issue cycle.
- R8: A paired op (class 9) needs both integer ALUs free. It is granted on the turn unit, the other integer ALU is occupied in the following cycle, and the integer turn flips.
- R9: Memory instructions (class 4) go to the memory port and occupy it for the issue cycle only.
- R10: An unrecognised class (10 to 15) is accepted only when all five units are free. It then raises all five grant bits, occupies the units for that cycle only and leaves both turn bits unchanged.
- R11: When the required unit or units are occupied, accept and grant are low and no state changes. The same instruction is granted on the first cycle its unit is free.
- R12: With the valid flag low, accept and grant are low and neither turn bit moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_class | input | 4 | Instruction class code |
| accept | output | 1 | The offered instruction is issued this cycle |
| grant | output | 5 | Units receiving the instruction (bit 0 int A … bit 4 memory) |

## Verification
Accept and grant are due in the same cycle the instruction is offered. The bench therefore drives the inputs on the falling edge and compares the outputs two nanoseconds later, before the rising edge that commits the issue. Occupancy and turn changes take effect from the next cycle onward. The bench's behavioural model records, for each unit, the cycle number at which that unit becomes free again. Each cycle's expected grant is derived from those cycle numbers and the model's turn bits, so multi-cycle holds, the one-cycle lag of the paired op and retries after a stall are all checked on the exact cycle they are due.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NUM_UNITS = 5;

  localparam int U_IALU_A = 0;
  localparam int U_IALU_B = 1;
  localparam int U_FALU_A = 2;
  localparam int U_FALU_B = 3;
  localparam int U_MEM    = 4;

  localparam logic [3:0] CLS_IFLEX   = 4'd0;
  localparam logic [3:0] CLS_CTRL    = 4'd1;
  localparam logic [3:0] CLS_IMUL    = 4'd2;
  localparam logic [3:0] CLS_IDIV    = 4'd3;
  localparam logic [3:0] CLS_MEM     = 4'd4;
  localparam logic [3:0] CLS_FSIMPLE = 4'd5;
  localparam logic [3:0] CLS_FFLEX   = 4'd6;
  localparam logic [3:0] CLS_FDIV    = 4'd7;
  localparam logic [3:0] CLS_FSQRT   = 4'd8;
  localparam logic [3:0] CLS_PAIR    = 4'd9;
endpackage

// File: rtl/unit_occupancy.sv
module unit_occupancy #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (remain != '0)
      remain <= remain - CNT_W'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/steer_pick.sv
module steer_pick
  import steer_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int IMUL_CYC  = 2,
  parameter int IDIV_CYC  = 19,
  parameter int FDIV_CYC  = 8,
  parameter int FSQRT_CYC = 14
) (
  input  logic                            valid,
  input  logic [3:0]                      cls,
  input  logic [NUM_UNITS-1:0]            busy,
  input  logic                            int_turn,
  input  logic                            fp_turn,
  output logic                            accept,
  output logic [NUM_UNITS-1:0]            grant,
  output logic [NUM_UNITS-1:0]            load,
  output logic [NUM_UNITS-1:0][CNT_W-1:0] load_val,
  output logic                            int_turn_nxt,
  output logic                            fp_turn_nxt
);
  logic [NUM_UNITS-1:0] g;
  logic [NUM_UNITS-1:0] second;
  logic [2:0]           it_u, io_u, ft_u, fo_u;

  always_comb begin
    g            = '0;
    second       = '0;
    load_val     = '0;
    int_turn_nxt = int_turn;
    fp_turn_nxt  = fp_turn;
    it_u = int_turn ? 3'(U_IALU_B) : 3'(U_IALU_A);
    io_u = int_turn ? 3'(U_IALU_A) : 3'(U_IALU_B);
    ft_u = fp_turn  ? 3'(U_FALU_B) : 3'(U_FALU_A);
    fo_u = fp_turn  ? 3'(U_FALU_A) : 3'(U_FALU_B);

    case (cls)
      CLS_IFLEX: begin
        if (!busy[it_u])      g[it_u] = 1'b1;
        else if (!busy[io_u]) g[io_u] = 1'b1;
        if (g != '0) int_turn_nxt = ~int_turn;
      end
      CLS_CTRL: if (!busy[U_IALU_A]) begin
        g[U_IALU_A]  = 1'b1;
        int_turn_nxt = 1'b1;
      end
      CLS_IMUL: if (!busy[U_IALU_B]) begin
        g[U_IALU_B]        = 1'b1;
        load_val[U_IALU_B] = CNT_W'(IMUL_CYC - 1);
        int_turn_nxt       = 1'b0;
      end
      CLS_IDIV: if (!busy[U_IALU_B]) begin
        g[U_IALU_B]        = 1'b1;
        load_val[U_IALU_B] = CNT_W'(IDIV_CYC - 1);
        int_turn_nxt       = 1'b0;
      end
      CLS_MEM: if (!busy[U_MEM]) g[U_MEM] = 1'b1;
      CLS_FSIMPLE: if (!busy[U_FALU_A]) begin
        g[U_FALU_A] = 1'b1;
        fp_turn_nxt = 1'b1;
      end
      CLS_FFLEX: begin
        if (!busy[ft_u])      g[ft_u] = 1'b1;
        else if (!busy[fo_u]) g[fo_u] = 1'b1;
        if (g != '0) fp_turn_nxt = ~fp_turn;
      end
      CLS_FDIV: if (!busy[U_FALU_B]) begin
        g[U_FALU_B]        = 1'b1;
        load_val[U_FALU_B] = CNT_W'(FDIV_CYC - 1);
        fp_turn_nxt        = 1'b0;
      end
      CLS_FSQRT: if (!busy[U_FALU_B]) begin
        g[U_FALU_B]        = 1'b1;
        load_val[U_FALU_B] = CNT_W'(FSQRT_CYC - 1);
        fp_turn_nxt        = 1'b0;
      end
      CLS_PAIR: if (!busy[U_IALU_A] && !busy[U_IALU_B]) begin
        g[it_u]        = 1'b1;
        second[io_u]   = 1'b1;
        load_val[io_u] = CNT_W'(1);
        int_turn_nxt   = ~int_turn;
      end
      default: if (busy == '0) g = '1;
    endcase

    if (!valid) begin
      g            = '0;
      second       = '0;
      int_turn_nxt = int_turn;
      fp_turn_nxt  = fp_turn;
    end
    grant  = g;
    load   = g | second;
    accept = (g != '0);
  end
endmodule

// File: rtl/issue_steer.sv
module issue_steer
  import steer_pkg::*;
#(
  parameter int IMUL_CYC  = 2,
  parameter int IDIV_CYC  = 19,
  parameter int FDIV_CYC  = 8,
  parameter int FSQRT_CYC = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [3:0] in_class,
  output logic       accept,
  output logic [4:0] grant
);
  localparam int MAX_A = (IMUL_CYC > IDIV_CYC) ? IMUL_CYC : IDIV_CYC;
  localparam int MAX_B = (FDIV_CYC > FSQRT_CYC) ? FDIV_CYC : FSQRT_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic                            int_turn, fp_turn;
  logic                            int_turn_nxt, fp_turn_nxt;
  logic [NUM_UNITS-1:0]            busy, load;
  logic [NUM_UNITS-1:0][CNT_W-1:0] load_val;

  steer_pick #(
    .CNT_W(CNT_W), .IMUL_CYC(IMUL_CYC), .IDIV_CYC(IDIV_CYC),
    .FDIV_CYC(FDIV_CYC), .FSQRT_CYC(FSQRT_CYC)
  ) u_pick (
    .valid(in_valid), .cls(in_class), .busy(busy),
    .int_turn(int_turn), .fp_turn(fp_turn),
    .accept(accept), .grant(grant), .load(load), .load_val(load_val),
    .int_turn_nxt(int_turn_nxt), .fp_turn_nxt(fp_turn_nxt)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    unit_occupancy #(.CNT_W(CNT_W)) u_occ (
      .clk(clk), .rst(rst), .load(load[u]),
      .load_val(load_val[u]), .busy(busy[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_turn <= 1'b0;
      fp_turn  <= 1'b0;
    end else begin
      int_turn <= int_turn_nxt;
      fp_turn  <= fp_turn_nxt;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy == '0) && !int_turn && !fp_turn);
  a_r2_flex_flips: assert property (@(posedge clk) disable iff (rst)
    accept && in_class == CLS_IFLEX |=> int_turn != $past(int_turn));
  a_r3_no_grant_to_busy: assert property (@(posedge clk) disable iff (rst)
    (grant & busy) == '0);
  a_r5_idiv_holds: assert property (@(posedge clk) disable iff (rst)
    accept && in_class == CLS_IDIV |=> busy[U_IALU_B]);
  a_r7_fsqrt_holds: assert property (@(posedge clk) disable iff (rst)
    accept && in_class == CLS_FSQRT |=> busy[U_FALU_B]);
  a_r8_pair_second: assert property (@(posedge clk) disable iff (rst)
    accept && in_class == CLS_PAIR |=> $countones(busy[1:0]) == 1);
  a_r11_stall_keeps_turns: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(int_turn) && $stable(fp_turn));
endmodule

// File: tb/issue_steer_test.sv
module issue_steer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_class = 4'd0;
  logic       accept;
  logic [4:0] grant;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    free_at [5];
  bit    mt_int, mt_fp;
  bit    last_ea;
  bit    r1_window;
  string tagv;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  issue_steer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .accept(accept), .grant(grant)
  );

  function automatic bit fr(int u);
    return free_at[u] <= cyc;
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 5; u++) free_at[u] = 0;
    mt_int = 0;
    mt_fp  = 0;
  endtask

  task automatic flex_pair(input int base, inout bit turn, output logic [4:0] eg);
    int t, o, u;
    t = base + (turn ? 1 : 0);
    o = base + (turn ? 0 : 1);
    u = -1;
    if (fr(t)) u = t;
    else if (fr(o)) begin u = o; tagv = "R3"; end
    if (u >= 0) begin
      eg[u]      = 1'b1;
      free_at[u] = cyc + 1;
      turn       = !turn;
    end
  endtask

  task automatic model(input bit v, input logic [3:0] c, output bit ea, output logic [4:0] eg);
    eg = '0;
    if (!v) tagv = "R12";
    else begin
      case (c)
        4'd0: begin tagv = "R2"; flex_pair(0, mt_int, eg); end
        4'd1: begin tagv = "R4"; if (fr(0)) begin eg = 5'b00001; free_at[0] = cyc + 1; mt_int = 1; end end
        4'd2: begin tagv = "R5"; if (fr(1)) begin eg = 5'b00010; free_at[1] = cyc + 2; mt_int = 0; end end
        4'd3: begin tagv = "R5"; if (fr(1)) begin eg = 5'b00010; free_at[1] = cyc + 19; mt_int = 0; end end
        4'd4: begin tagv = "R9"; if (fr(4)) begin eg = 5'b10000; free_at[4] = cyc + 1; end end
        4'd5: begin tagv = "R6"; if (fr(2)) begin eg = 5'b00100; free_at[2] = cyc + 1; mt_fp = 1; end end
        4'd6: begin tagv = "R6"; flex_pair(2, mt_fp, eg); end
        4'd7: begin tagv = "R7"; if (fr(3)) begin eg = 5'b01000; free_at[3] = cyc + 8; mt_fp = 0; end end
        4'd8: begin tagv = "R7"; if (fr(3)) begin eg = 5'b01000; free_at[3] = cyc + 14; mt_fp = 0; end end
        4'd9: begin
          tagv = "R8";
          if (fr(0) && fr(1)) begin
            int f;
            f = mt_int ? 1 : 0;
            eg[f] = 1'b1;
            free_at[f] = cyc + 1;
            free_at[1-f] = cyc + 2;
            mt_int = !mt_int;
          end
        end
        default: begin
          tagv = "R10";
          if (fr(0) && fr(1) && fr(2) && fr(3) && fr(4)) begin
            eg = 5'b11111;
            for (int u = 0; u < 5; u++) free_at[u] = cyc + 1;
          end
        end
      endcase
      if (eg == '0) tagv = "R11";
    end
    if (r1_window) tagv = "R1";
    ea = (eg != '0);
  endtask

  task automatic check_cycle();
    bit ea;
    logic [4:0] eg;
    model(in_valid, in_class, ea, eg);
    last_ea = ea;
    checks++;
    if (accept !== ea || grant !== eg) begin
      errors++;
      $display("FAIL %s cyc=%0d class=%0d actual accept=%b grant=%b expected accept=%b grant=%b",
               tagv, cyc, in_class, accept, grant, ea, eg);
    end
  endtask

  task automatic issue(input logic [3:0] c);
    do begin
      @(negedge clk);
      in_valid = 1'b1;
      in_class = c;
      #2;
      check_cycle();
    end while (!last_ea);
  endtask

  task automatic idle(input int n, input logic [3:0] c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_class = c;
      #2;
      check_cycle();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  logic [3:0] seq [32] = '{4'd0, 4'd0, 4'd0, 4'd6, 4'd6, 4'd1, 4'd0, 4'd2,
                           4'd0, 4'd3, 4'd0, 4'd0, 4'd0, 4'd2, 4'd5, 4'd6,
                           4'd7, 4'd6, 4'd6, 4'd8, 4'd7, 4'd4, 4'd4, 4'd9,
                           4'd9, 4'd0, 4'd10, 4'd15, 4'd1, 4'd9, 4'd3, 4'd9};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    r1_window = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state visible at the ports
    r1_window = 1;
    idle(1, 4'd0);
    issue(4'd0);
    issue(4'd6);
    r1_window = 0;
    idle(2, 4'd3);
    foreach (seq[i]) issue(seq[i]);
    // R1: reset in the middle of a long hold frees the unit
    issue(4'd3);
    do_reset();
    r1_window = 1;
    issue(4'd2);
    issue(4'd0);
    r1_window = 0;
    // mixed traffic from a 16-bit LFSR
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:13] == 3'd0) idle(1, lfsr[3:0]);
      else if (lfsr[3:0] >= 4'd10 && lfsr[4]) issue(4'(lfsr[7:4] % 10));
      else issue(lfsr[3:0]);
    end
    idle(2, 4'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule